// File: doc/BRIEF.md
# LCD Common Drive Sequencer

This block turns a slow oscillator tick, or a common waveform supplied from outside, into the timing for the common electrodes of a segment LCD. It produces a square common-out phase. It also produces a level code for each of the two common electrodes, A and B. A flag tells the segment logic which data bank to show. Two display modes are supported. In static mode both commons swing together. In half-duty dynamic mode one common is selected and swings between high and low while the other rests at the middle level. The selected common changes after every common-out period.

When several devices drive one panel, they share a single open-drain sync wire with one pull-up. A device running from its own oscillator in dynamic mode pulls that wire low at the start of each com-A select period. Every other device that sees the wire fall without pulling it itself restarts its phase at the same point, so all the commons stay in step. In static mode the device holds the wire low. The analog levels and the oscillator itself lie outside the block.

Top module: `lcd_common_gen`

## Requirements
- R1: In internal static mode (`ext_sel`=0, `dyn_sel`=0), `com_out` is 0 for 4 ticks and 1 for the next 4 ticks, starting with 0 at reset. This gives a period of 8 `osc_tick` pulses.
- R2: In internal dynamic mode (`ext_sel`=0, `dyn_sel`=1), `com_out` is 0 for 2 ticks and 1 for 2 ticks, starting with 0 at reset. This gives a period of 4 ticks.
- R3: In external mode (`ext_sel`=1), `com_out` equals `ext_com` delayed by one clock. In dynamic external mode the selected common changes at every falling edge of `com_out`, and the selection starts on com-A after reset. In dynamic external mode `sync_pull` is 0.
- R4: In static mode `com_a` and `com_b` are both 2'b10 while `com_out` is 1, and both 2'b00 while `com_out` is 0. `a_select` is 1.
- R5: In dynamic mode the selected common is 2'b10 while `com_out` is 1 and 2'b00 while `com_out` is 0. The other common is 2'b01. The code 2'b11 never appears.
- R6: In internal dynamic mode com-A is selected (`a_select`=1) for the first full `com_out` period after reset or after a phase restart. com-B is selected for the next period, and the pattern then repeats.
- R7: In internal dynamic mode `sync_pull` is 1 from the tick that begins a com-A select period until the following tick, and 0 otherwise. In static mode `sync_pull` is 1 at all times.
- R8: In internal dynamic mode, a falling edge on `sync_in` that occurs while this device is not pulling restarts the phase at the beginning of com-A select. An `osc_tick` on the same clock is counted as the first tick of the new phase.
- R9: Two devices in internal dynamic mode that share one sync wire show identical `com_out`, `com_a`, `com_b` and `a_select` once either of them has begun a com-A period. This holds even when their counts started apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-clock pulse per oscillator cycle |
| ext_sel | input | 1 | 1: use `ext_com` as the common; 0: divide `osc_tick` |
| dyn_sel | input | 1 | 1: half-duty dynamic mode; 0: static mode |
| ext_com | input | 1 | Externally supplied common waveform |
| sync_in | input | 1 | Level sensed on the shared sync wire |
| com_out | output | 1 | Common phase, fed to chained devices |
| com_a | output | 2 | Level code for common A (00 low, 01 middle, 10 high) |
| com_b | output | 2 | Level code for common B (same coding) |
| sync_pull | output | 1 | 1 drives the shared sync wire low |
| a_select | output | 1 | 1 while bank A data should be shown |

## Verification
A phase restart caused by the sync wire and an oscillator tick can land on the same clock edge. If the tick were dropped, the device would sit one tick behind its neighbours for the whole period. The bench pulls the wire low once with no tick present and once together with a tick. It then judges the resulting phase by how many further ticks it takes for `com_out` to rise: two in the first case, one in the second. A device that sees its own pull on the wire must not restart, and the bench confirms this by letting the counter wrap normally through its own pulse.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;
endpackage

// File: rtl/lcd_com_divider.sv
module lcd_com_divider #(
    parameter int STATIC_DIV = 8,
    parameter int DYN_DIV    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dyn,
    input  logic tick,
    input  logic sync_in,
    output logic com_out,
    output logic sel_b,
    output logic pull
);
    localparam int STATIC_LAST = STATIC_DIV - 1;
    localparam int DYN_LAST    = 2 * DYN_DIV - 1;
    localparam int CNT_MAX     = (STATIC_LAST > DYN_LAST) ? STATIC_LAST : DYN_LAST;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pull;
        logic             sync_prev;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] last_c, phase_c;
    logic wrap_c, fall_c, resync_c;

    always_comb begin
        last_c   = dyn ? CNT_W'(DYN_LAST) : CNT_W'(STATIC_LAST);
        wrap_c   = tick && (st_q.cnt >= last_c);
        fall_c   = st_q.sync_prev && !sync_in;
        resync_c = en && dyn && fall_c && !st_q.pull;
        st_d           = st_q;
        st_d.sync_prev = sync_in;
        if (!en) begin
            st_d.cnt  = '0;
            st_d.pull = 1'b0;
        end else if (resync_c) begin
            st_d.cnt  = tick ? CNT_W'(1) : '0;
            st_d.pull = 1'b0;
        end else if (tick) begin
            st_d.cnt  = wrap_c ? '0 : st_q.cnt + 1'b1;
            st_d.pull = dyn && wrap_c;
        end
        if (!dyn) st_d.pull = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt       <= '0;
            st_q.pull      <= 1'b0;
            st_q.sync_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel_b   = dyn && (st_q.cnt >= CNT_W'(DYN_DIV));
        phase_c = sel_b ? st_q.cnt - CNT_W'(DYN_DIV) : st_q.cnt;
        com_out = dyn ? (phase_c >= CNT_W'(DYN_DIV / 2))
                      : (st_q.cnt >= CNT_W'(STATIC_DIV / 2));
        pull    = st_q.pull;
    end

    // R1 / R2: the phase only advances on a tick or a restart
    assert_cnt_moves_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && en && !$past(tick) && !$past(resync_c)
        |-> $stable(st_q.cnt));

    // R8: a restart without a tick lands on the first half of com-A select
    assert_resync_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resync_c && !tick && dyn |=> (!sel_b && !com_out));
endmodule

// File: rtl/lcd_com_ext.sv
module lcd_com_ext (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ext_com,
    output logic com_out,
    output logic sel_b
);
    typedef struct packed {
        logic com;
        logic sel;
    } ext_state_t;

    ext_state_t st_d, st_q;

    always_comb begin
        st_d.com = ext_com;
        st_d.sel = st_q.sel ^ (st_q.com & ~ext_com);
        if (!en) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_out = st_q.com;
    assign sel_b   = st_q.sel;

    assert_ext_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && en |-> com_out == $past(ext_com));
endmodule

// File: rtl/lcd_com_levels.sv
module lcd_com_levels
    import lcd_com_pkg::*;
(
    input  logic       dyn,
    input  logic       com_in,
    input  logic       sel_b,
    output logic [1:0] com_a,
    output logic [1:0] com_b,
    output logic       a_sel
);
    lvl_e swing_c;

    always_comb begin
        swing_c = com_in ? LVL_HIGH : LVL_LOW;
        if (!dyn) begin
            com_a = swing_c;
            com_b = swing_c;
            a_sel = 1'b1;
        end else begin
            com_a = sel_b ? LVL_MID : swing_c;
            com_b = sel_b ? swing_c : LVL_MID;
            a_sel = !sel_b;
        end
    end
endmodule

// File: rtl/lcd_common_gen.sv
module lcd_common_gen
    import lcd_com_pkg::*;
#(
    parameter int STATIC_DIV = 8,
    parameter int DYN_DIV    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       ext_sel,
    input  logic       dyn_sel,
    input  logic       ext_com,
    input  logic       sync_in,
    output logic       com_out,
    output logic [1:0] com_a,
    output logic [1:0] com_b,
    output logic       sync_pull,
    output logic       a_select
);
    logic div_com, div_sel_b, div_pull;
    logic ext_com_q, ext_sel_b;
    logic sel_b_c;

    lcd_com_divider #(.STATIC_DIV(STATIC_DIV), .DYN_DIV(DYN_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .en(!ext_sel), .dyn(dyn_sel),
        .tick(osc_tick), .sync_in(sync_in),
        .com_out(div_com), .sel_b(div_sel_b), .pull(div_pull)
    );

    lcd_com_ext u_ext (
        .clk(clk), .rst_n(rst_n), .en(ext_sel), .ext_com(ext_com),
        .com_out(ext_com_q), .sel_b(ext_sel_b)
    );

    always_comb begin
        com_out   = ext_sel ? ext_com_q : div_com;
        sel_b_c   = ext_sel ? ext_sel_b : div_sel_b;
        sync_pull = !dyn_sel || (!ext_sel && div_pull);
    end

    lcd_com_levels u_lvl (
        .dyn(dyn_sel), .com_in(com_out), .sel_b(sel_b_c),
        .com_a(com_a), .com_b(com_b), .a_sel(a_select)
    );

    assert_static_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dyn_sel |-> (com_a == com_b) && a_select);

    assert_one_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_sel |-> ((com_a == LVL_MID) != (com_b == LVL_MID)));

    assert_no_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (com_a != 2'b11) && (com_b != 2'b11));

    assert_pull_in_a_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_sel && sync_pull |-> a_select && !com_out);
endmodule

// File: tb/tb_lcd_common_gen.sv
`timescale 1ns/1ps
module tb_lcd_common_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_a = 1'b0, tick_b = 1'b0;
    logic ext_sel = 1'b0, dyn_sel = 1'b0, ext_com = 1'b0;
    logic pair_en = 1'b0, force_low = 1'b0;
    logic sync_line;
    logic co_a, co_b, pull_a, pull_b, as_a, as_b;
    logic [1:0] ca_a, cb_a, ca_b, cb_b;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sync_line = ~(pull_a | (pair_en & pull_b) | force_low);

    lcd_common_gen dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(tick_a), .ext_sel(ext_sel),
        .dyn_sel(dyn_sel), .ext_com(ext_com), .sync_in(sync_line),
        .com_out(co_a), .com_a(ca_a), .com_b(cb_a), .sync_pull(pull_a), .a_select(as_a)
    );

    lcd_common_gen dut2 (
        .clk(clk), .rst_n(rst_n), .osc_tick(tick_b), .ext_sel(ext_sel),
        .dyn_sel(dyn_sel), .ext_com(ext_com), .sync_in(sync_line),
        .com_out(co_b), .com_a(ca_b), .com_b(cb_b), .sync_pull(pull_b), .a_select(as_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // packed {com_out, com_a, com_b, a_select} expected after c ticks of phase
    function automatic logic [7:0] expect_int(input bit dyn, input int c);
        logic co, sb;
        logic [1:0] lv;
        if (!dyn) begin
            co = (c % 8) >= 4;
            lv = co ? 2'b10 : 2'b00;
            return {2'b00, co, lv, lv, 1'b1};
        end
        sb = (c % 8) >= 4;
        co = (c % 4) >= 2;
        lv = co ? 2'b10 : 2'b00;
        return {2'b00, co, sb ? 2'b01 : lv, sb ? lv : 2'b01, !sb};
    endfunction

    function automatic logic [7:0] obs_a();
        return {2'b00, co_a, ca_a, cb_a, as_a};
    endfunction

    function automatic logic [7:0] obs_b();
        return {2'b00, co_b, ca_b, cb_b, as_b};
    endfunction

    task automatic do_reset(input bit ext, input bit dyn);
        @(negedge clk);
        rst_n = 1'b0; ext_sel = ext; dyn_sel = dyn; ext_com = 1'b0;
        pair_en = 1'b0; force_low = 1'b0; tick_a = 1'b0; tick_b = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick_both(input bit with_force);
        @(negedge clk);
        tick_a = 1'b1; tick_b = 1'b1; force_low = with_force;
        @(negedge clk);
        tick_a = 1'b0; tick_b = 1'b0; force_low = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_static;
        do_reset(0, 0);
        chk("R1 reset phase", obs_a(), expect_int(0, 0));
        chk("R7 static pull", {7'd0, pull_a}, 8'd1);
        for (int k = 1; k <= 16; k++) begin
            tick_both(0);
            chk("R1/R4 static divide", obs_a(), expect_int(0, k));
            chk("R7 static pull held", {7'd0, pull_a}, 8'd1);
        end
    endtask

    task automatic test_dynamic;
        do_reset(0, 1);
        chk("R2 reset phase", obs_a(), expect_int(1, 0));
        chk("R7 no pull at reset", {7'd0, pull_a}, 8'd0);
        for (int k = 1; k <= 20; k++) begin
            tick_both(0);
            chk("R2/R5/R6 dynamic divide", obs_a(), expect_int(1, k));
            chk("R7 pull at com-A start", {7'd0, pull_a}, {7'd0, (k % 8) == 0});
        end
    endtask

    task automatic test_resync;
        do_reset(0, 1);
        repeat (5) tick_both(0);
        chk("R8 before restart", obs_a(), expect_int(1, 5));
        @(negedge clk); force_low = 1'b1;
        @(negedge clk); force_low = 1'b0;
        @(negedge clk);
        chk("R8 restart no tick", obs_a(), expect_int(1, 0));
        tick_both(0);
        chk("R8 one tick after restart", obs_a(), expect_int(1, 1));
        tick_both(0);
        chk("R8 two ticks after restart", obs_a(), expect_int(1, 2));
        repeat (3) tick_both(0);
        chk("R8 before tick restart", obs_a(), expect_int(1, 5));
        tick_both(1);
        chk("R8 restart with tick", obs_a(), expect_int(1, 1));
        tick_both(0);
        chk("R8 tick counted", obs_a(), expect_int(1, 2));
    endtask

    task automatic test_pair;
        do_reset(0, 1);
        pair_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); tick_b = 1'b1;
            @(negedge clk); tick_b = 1'b0;
        end
        @(negedge clk);
        for (int k = 1; k <= 12; k++) begin
            tick_both(0);
            if (k >= 6) chk("R9 pair aligned", obs_a(), obs_b());
        end
        chk("R9 leader phase", obs_b(), expect_int(1, 15));
        chk("R9 follower phase", obs_a(), expect_int(1, 15));
    endtask

    task automatic ext_step(input logic v, input logic [7:0] exp, input string req);
        @(negedge clk); ext_com = v;
        @(negedge clk);
        chk(req, obs_a(), exp);
    endtask

    task automatic test_external;
        do_reset(1, 1);
        chk("R3 ext dyn no pull", {7'd0, pull_a}, 8'd0);
        ext_step(1, {2'b00, 1'b1, 2'b10, 2'b01, 1'b1}, "R3 ext high A sel");
        ext_step(0, {2'b00, 1'b0, 2'b01, 2'b00, 1'b0}, "R3 ext fall to B");
        ext_step(1, {2'b00, 1'b1, 2'b01, 2'b10, 1'b0}, "R3 ext high B sel");
        ext_step(0, {2'b00, 1'b0, 2'b00, 2'b01, 1'b1}, "R3 ext fall to A");
        chk("R3 ext dyn no pull later", {7'd0, pull_a}, 8'd0);
        do_reset(1, 0);
        ext_step(1, {2'b00, 1'b1, 2'b10, 2'b10, 1'b1}, "R3/R4 ext static high");
        ext_step(0, {2'b00, 1'b0, 2'b00, 2'b00, 1'b1}, "R3/R4 ext static low");
    endtask

    initial begin
        test_static;
        test_dynamic;
        test_resync;
        test_pair;
        test_external;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule